// File: doc/BRIEF.md
# Successive-Approximation Sequencer for a Binary-Weighted Capacitor DAC

This block is the digital sequencer of an N-bit successive-approximation converter. Its analog partner is a charge-redistribution array of binary-weighted capacitors, plus one extra unit capacitor that is never switched. A comparator watches the shared top-plate node of that array. The block accepts a one-cycle start request and the comparator decision. It drives three sets of controls: the top-plate grounding switch, the input-select control for the bottom plates, and one bottom-plate line per weighted capacitor (1 = reference, 0 = ground). When a conversion ends, it delivers the N-bit code together with a one-cycle done strobe.

While idle, the array tracks the input: the top plate is grounded and every bottom plate is on the input. A start request adds one more tracking cycle, which is the sample cycle. The top-plate switch then opens and one bit is resolved in each cycle, from MSB to LSB.

The node voltage is the trial voltage minus the held input. The comparator therefore goes high when the trial exceeds the input, and in that case the bit just tried is 0. Each decision and the next trial are applied on the same clock edge. A conversion uses N+1 cycles.

Top module: `sar_cdac_ctrl`

## Requirements
- R1: While idle, and during the sample cycle, `sampleSw` and `selInput` are both 1, `plateRef` is all zeros and `doneStrobe` is 0.
- R2: A start request seen at a clock edge while idle is followed by exactly one sample cycle, which has `sampleSw`=1.
- R3: In the first bit cycle after the sample cycle, `sampleSw` and `selInput` are 0 and `plateRef` has only bit N-1 set (the half-scale trial).
- R4: At the end of each bit cycle, `cmpHigh`=1 clears the plate bit under trial and `cmpHigh`=0 keeps it set. On the same edge, the bit of next lower weight is set as the new trial.
- R5: A conversion uses N+1 cycles: one sample cycle and N bit cycles. `doneStrobe` is 1 in the cycle that follows the LSB bit cycle.
- R6: With the comparator driven by an ideal array, `resultCode` equals floor(Vin·2^N/Vref) for every input. The code changes only when `doneStrobe` rises and is held through the next conversion.
- R7: A start request during the sample cycle or during a bit cycle has no effect: no extra conversion follows it.
- R8: `doneStrobe` stays high for exactly one cycle. A start request in that cycle is accepted.
- R9: During the bit cycles, `plateRef` is never all zeros. The trial bit is always set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startReq | input | 1 | One-cycle conversion request |
| cmpHigh | input | 1 | Comparator output, 1 when the top-plate node is above zero |
| sampleSw | output | 1 | Top-plate grounding switch, 1 = closed |
| selInput | output | 1 | Bottom plates on the analog input when 1 |
| plateRef | output | N | Per-capacitor bottom-plate select, 1 = reference, 0 = ground (bit k has weight 2^k) |
| resultCode | output | N | Last converted code |
| doneStrobe | output | 1 | One-cycle pulse when `resultCode` is updated |

## Verification
The assertions check on every cycle that the two tracking controls move together and that no plate reaches the reference while tracking. They also check that each done pulse lasts one cycle, that it arrives exactly N bit cycles after the switch opens, that a trial is always present while converting, and that the code never changes between pulses. Only the bench scenarios can show that the decision polarity and the final code are correct for every input. The bench does this against an integer charge-balance model at quarter-LSB resolution. The same scenarios show that stray start requests are absorbed and that a start request in the done cycle chains the next conversion.

// File: rtl/sar_pkg.sv
package sar_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SAMPLE,
    ST_CONVERT
  } sarState_t;

  typedef struct packed {
    logic load;    // enter first bit cycle: place half-scale trial
    logic step;    // resolve current bit, place next trial
    logic finish;  // resolve LSB, publish code
  } sarStrobe_t;

endpackage

// File: rtl/sar_ctrl.sv
module sar_ctrl
  import sar_pkg::*;
#(
  parameter int N = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       startReq,
  output sarStrobe_t strobe,
  output logic       trackEn
);

  localparam int CW = (N > 1) ? $clog2(N) : 1;

  sarState_t       state;
  logic [CW-1:0]   bitCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      bitCnt <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (startReq) state <= ST_SAMPLE;
        end
        ST_SAMPLE: begin
          state  <= ST_CONVERT;
          bitCnt <= CW'(N - 1);
        end
        ST_CONVERT: begin
          if (bitCnt == '0) state <= ST_IDLE;
          else              bitCnt <= bitCnt - 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe.load   = (state == ST_SAMPLE);
    strobe.step   = (state == ST_CONVERT) && (bitCnt != '0);
    strobe.finish = (state == ST_CONVERT) && (bitCnt == '0);
    trackEn       = (state != ST_CONVERT);
  end

endmodule

// File: rtl/sar_datapath.sv
module sar_datapath
  import sar_pkg::*;
#(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  sarStrobe_t   strobe,
  input  logic         cmpHigh,
  output logic [N-1:0] plateRef,
  output logic [N-1:0] resultCode,
  output logic         doneStrobe
);

  localparam logic [N-1:0] HALF_SCALE = {1'b1, {(N-1){1'b0}}};

  logic [N-1:0] trialMask;
  logic [N-1:0] plateReg;
  logic [N-1:0] fixedPlates;

  // Node above zero means the trial exceeds the input: drop the trial cap.
  always_comb begin
    fixedPlates = cmpHigh ? (plateReg & ~trialMask) : plateReg;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      trialMask  <= '0;
      plateReg   <= '0;
      resultCode <= '0;
      doneStrobe <= 1'b0;
    end else begin
      doneStrobe <= strobe.finish;
      if (strobe.load) begin
        trialMask <= HALF_SCALE;
        plateReg  <= HALF_SCALE;
      end else if (strobe.step) begin
        plateReg  <= fixedPlates | (trialMask >> 1);
        trialMask <= trialMask >> 1;
      end else if (strobe.finish) begin
        resultCode <= fixedPlates;
        plateReg   <= '0;
        trialMask  <= '0;
      end
    end
  end

  assign plateRef = plateReg;

endmodule

// File: rtl/sar_cdac_ctrl.sv
module sar_cdac_ctrl
  import sar_pkg::*;
#(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         startReq,
  input  logic         cmpHigh,
  output logic         sampleSw,
  output logic         selInput,
  output logic [N-1:0] plateRef,
  output logic [N-1:0] resultCode,
  output logic         doneStrobe
);

  sarStrobe_t strobe;
  logic       trackEn;

  sar_ctrl #(.N(N)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .startReq (startReq),
    .strobe   (strobe),
    .trackEn  (trackEn)
  );

  sar_datapath #(.N(N)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .cmpHigh    (cmpHigh),
    .plateRef   (plateRef),
    .resultCode (resultCode),
    .doneStrobe (doneStrobe)
  );

  assign sampleSw = trackEn;
  assign selInput = trackEn;

endmodule

// File: rtl/sar_cdac_ctrl_chk.sv
module sar_cdac_ctrl_chk #(
  parameter int N = 8
) (
  input logic         clk,
  input logic         rstN,
  input logic         sampleSw,
  input logic         selInput,
  input logic [N-1:0] plateRef,
  input logic [N-1:0] resultCode,
  input logic         doneStrobe
);

  localparam int CW = $clog2(N + 2);

  logic [CW-1:0] openCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         openCnt <= '0;
    else if (sampleSw) openCnt <= '0;
    else               openCnt <= openCnt + 1'b1;
  end

  // R1
  track_pair_chk: assert property (@(posedge clk) disable iff (!rstN)
    sampleSw == selInput);

  // R1
  no_ref_while_track_chk: assert property (@(posedge clk) disable iff (!rstN)
    sampleSw |-> (plateRef == '0));

  // R8
  done_one_cycle_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneStrobe |=> !doneStrobe);

  // R5
  done_after_n_bits_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneStrobe |-> (sampleSw && openCnt == CW'(N)));

  // R5
  bit_window_chk: assert property (@(posedge clk) disable iff (!rstN)
    !sampleSw |-> (openCnt < CW'(N)));

  // R9
  trial_present_chk: assert property (@(posedge clk) disable iff (!rstN)
    !sampleSw |-> (plateRef != '0));

  // R6
  code_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !doneStrobe |=> (!doneStrobe |-> $stable(resultCode)));

endmodule

bind sar_cdac_ctrl sar_cdac_ctrl_chk #(.N(N)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .sampleSw   (sampleSw),
  .selInput   (selInput),
  .plateRef   (plateRef),
  .resultCode (resultCode),
  .doneStrobe (doneStrobe)
);

// File: tb/sar_cdac_ctrl_tb.sv
module sar_cdac_ctrl_tb;

  localparam int N = 8;
  localparam int FULL = 1 << N;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         startReq = 1'b0;
  logic         cmpHigh;
  logic         sampleSw, selInput, doneStrobe;
  logic [N-1:0] plateRef, resultCode;

  int vinQ = 0;    // input in quarter-LSB units
  int heldQ = 0;   // value held on the array
  int checks = 0;
  int fails = 0;
  int doneCount = 0;
  int launches = 0;
  int expQ[$];

  always #2 clk = ~clk;   // 250 MHz

  sar_cdac_ctrl #(.N(N)) u_dut (
    .clk, .rstN, .startReq, .cmpHigh,
    .sampleSw, .selInput, .plateRef, .resultCode, .doneStrobe
  );

  // Ideal array: node = trial - held input, comparator high when node > 0.
  always @(posedge clk) if (sampleSw) heldQ <= vinQ;
  always_comb cmpHigh = ((int'(plateRef) * 4) - heldQ) > 0;

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // driver: called at a negedge, leaves at the next negedge
  task automatic launch(int vq);
    vinQ = vq;
    startReq = 1'b1;
    expQ.push_back(vq / 4);
    launches++;
    @(negedge clk);
    startReq = 1'b0;
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rstN && doneStrobe) begin
      doneCount++;
      if (expQ.size() == 0) check(1'b0, "R7 unexpected done", 1, 0);
      else begin
        int e;
        e = expQ.pop_front();
        check(int'(resultCode) == e, "R6 code", int'(resultCode), e);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    finishRun();
  end

  initial begin
    int codeA, codeB;
    codeA = (1 << (N-1)) | (1 << (N-3)) | 1;
    codeB = (1 << (N-3)) | 1;

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 idle state
    check(sampleSw && selInput, "R1 idle tracking", sampleSw, 1);
    check(plateRef == '0, "R1 idle plates", int'(plateRef), 0);
    check(!doneStrobe && resultCode == '0, "R1 reset code", int'(resultCode), 0);

    launch(codeA * 4 + 1);
    // R2 sample cycle
    check(sampleSw && selInput && plateRef == '0, "R2 sample cycle", int'(plateRef), 0);
    @(negedge clk);
    // R3 half-scale trial
    check(!sampleSw && !selInput, "R3 switch open", sampleSw, 0);
    check(int'(plateRef) == (1 << (N-1)), "R3 first trial", int'(plateRef), 1 << (N-1));
    startReq = 1'b1;   // stray request, R7
    @(negedge clk);
    startReq = 1'b0;
    // R4 MSB kept, next trial added
    check(int'(plateRef) == ((1 << (N-1)) | (1 << (N-2))), "R4 keep MSB",
          int'(plateRef), (1 << (N-1)) | (1 << (N-2)));
    repeat (N - 2) @(negedge clk);
    check(!doneStrobe, "R5 not early", doneStrobe, 0);
    @(negedge clk);
    check(doneStrobe, "R5 done at N+1", doneStrobe, 1);
    @(negedge clk);
    check(!doneStrobe, "R8 single pulse", doneStrobe, 0);
    repeat (4) begin
      @(negedge clk);
      check(sampleSw && !doneStrobe, "R7 stray start ignored", sampleSw, 1);
    end

    launch(codeB * 4 + 3);
    @(negedge clk);
    check(int'(resultCode) == codeA, "R6 code held", int'(resultCode), codeA);
    @(negedge clk);
    // R4 MSB dropped, next trial added
    check(int'(plateRef) == (1 << (N-2)), "R4 drop MSB", int'(plateRef), 1 << (N-2));
    repeat (N - 1) @(negedge clk);

    // exhaustive, back-to-back: start issued in the done cycle (R8)
    for (int q = 0; q < 4 * FULL; q++) begin
      launch(q);
      repeat (N + 1) @(negedge clk);
      check(doneStrobe, "R8 chained done", doneStrobe, 1);
    end
    launch(4 * FULL - 1);
    repeat (N + 6) @(negedge clk);
    check(expQ.size() == 0, "R6 all results seen", expQ.size(), 0);
    check(doneCount == launches, "R7 done count", doneCount, launches);
    check(int'(resultCode) == FULL - 1, "R6 full scale", int'(resultCode), FULL - 1);
    finishRun();
  end

endmodule